// File: doc/BRIEF.md
# CAN Receive Mailbox Matching Engine

This block decides where a received CAN frame identifier goes inside a bank of receive mailboxes. Each mailbox keeps a code state, a programmed identifier, a lock flag set by the CPU while it reads the mailbox, a serviced flag and an acceptance mask. When a frame arrives, the identifier is held in a staging register. The engine compares it against every active mailbox through that mailbox's mask. It then stores the frame in a chosen mailbox, writing the stored identifier, a timestamp and a new code and raising a one-cycle interrupt bit. If it cannot store the frame, it keeps the frame staged until the blocking mailbox is unlocked, or it drops a frame that matches nothing.

In queue mode (`compat_en` = 1), several mailboxes programmed with the same identifier form a queue. The frame goes to the lowest-index matching mailbox that is free. When none is free, the frame overwrites the highest-index matching mailbox and marks it OVERRUN. In legacy mode (`compat_en` = 0), the scan stops at the first match whether or not that mailbox is free. Legacy mode also replaces the per-mailbox masks with three shared masks.

The control is a four-state machine. IDLE moves to EVAL when a frame strobe arrives. EVAL moves to IDLE when nothing matches, to PEND when the chosen mailbox is locked, and to WRITE otherwise. WRITE always moves back to IDLE. PEND moves to EVAL in the first cycle in which the blocking mailbox is seen unlocked.

Top module: `can_rx_mbox_match`

## Requirements
- R1: After reset, every mailbox reads code INACTIVE and no interrupt bit is set. The code encoding is INACTIVE=0, EMPTY=1, FULL=2, OVERRUN=3. A configuration write sets a mailbox's identifier and its code (EMPTY when `cfg_on`=1, INACTIVE otherwise), and it clears the serviced flag.
- R2: A mailbox matches when it is not INACTIVE and its identifier equals the frame identifier in every bit whose mask bit is 1. Bits whose mask bit is 0 are ignored. In queue mode, each mailbox uses its own mask.
- R3: In queue mode, the frame is stored in the lowest-index matching mailbox that is free, and any matching mailbox that is not free is skipped. That mailbox's code becomes FULL, its stored identifier becomes the frame identifier, and exactly its interrupt bit goes high for one cycle. The interrupt bit is visible after the second rising edge that follows the edge sampling `frm_valid`.
- R4: A mailbox is free when it is unlocked and either its code is EMPTY, or its code is FULL or OVERRUN and it has been serviced. A mailbox is serviced once it has been locked and then unlocked. A store clears the serviced flag.
- R5: In queue mode, if no matching mailbox is free, the frame overwrites the highest-index matching mailbox and sets its code to OVERRUN.
- R6: If the mailbox chosen for an overwrite is locked, the frame is held and nothing is stored, and frame strobes that arrive while it is held are ignored. The held frame is stored on the third rising edge after the edge that unlocks that mailbox.
- R7: In legacy mode, the first matching mailbox is always the target. If that mailbox is free, the frame is stored as FULL. If it is not free and not locked, the frame is stored as OVERRUN. If it is locked, the frame is held as in R6.
- R8: In legacy mode, mailbox 14 uses the first dedicated mask, mailbox 15 uses the second dedicated mask, and every other mailbox uses the global mask. A legacy mask is selected by `msk_leg`=1 with `msk_sel` equal to 0 (global), 1 (mailbox 14) or 2 (mailbox 15).
- R9: A per-mailbox mask write (`msk_leg`=0) takes effect only while both `compat_en` and `freeze` are 1. A legacy mask write takes effect only while `freeze` is 1. Any other mask write leaves every mask unchanged.
- R10: A store records the value of a free-running counter that advances once per clock. Two stores made k cycles apart therefore differ in timestamp by k.
- R11: A frame that matches no mailbox is dropped, with no interrupt and no change to any mailbox.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frm_valid | input | 1 | One-cycle strobe for a received frame |
| frm_id | input | ID_W | Received frame identifier |
| compat_en | input | 1 | 1 selects queue mode with per-mailbox masks; 0 selects legacy mode |
| freeze | input | 1 | Freeze-mode flag that gates mask writes |
| cfg_we | input | 1 | Mailbox configuration write strobe |
| cfg_idx | input | IDX_W | Mailbox selected by the configuration write |
| cfg_id | input | ID_W | Identifier to program |
| cfg_on | input | 1 | 1 makes the mailbox EMPTY; 0 makes it INACTIVE |
| lk_we | input | 1 | Lock or unlock strobe |
| lk_idx | input | IDX_W | Mailbox to lock or unlock |
| lk_set | input | 1 | 1 locks the mailbox; 0 unlocks it |
| msk_we | input | 1 | Mask write strobe |
| msk_leg | input | 1 | 1 selects a legacy mask; 0 selects a per-mailbox mask |
| msk_sel | input | IDX_W | Mailbox index, or legacy mask number |
| msk_val | input | ID_W | Mask value |
| rd_idx | input | IDX_W | Mailbox selected for the read port |
| rd_code | output | 2 | Code of the selected mailbox |
| rd_ts | output | TS_W | Timestamp of the selected mailbox |
| rd_fid | output | ID_W | Last frame identifier stored in the selected mailbox |
| irq_o | output | NUM_MB | One-cycle per-mailbox store pulse |

## Verification
If the strobe is sampled at edge k, the store result appears two edges later, at k+2. At that point the interrupt vector and the new mailbox contents can be read, and the interrupt clears at k+3. A held frame is stored three edges after the unlocking edge. Two such stores in a row are spaced four cycles apart, which sets the expected timestamp difference. The bench drives inputs and samples outputs at falling edges, waits exactly those counts before every comparison, and gets each expected value from a mailbox model that it keeps itself.

// File: rtl/can_rxm_pkg.sv
package can_rxm_pkg;
    typedef enum logic [1:0] {
        CODE_INACTIVE = 2'd0,
        CODE_EMPTY    = 2'd1,
        CODE_FULL     = 2'd2,
        CODE_OVERRUN  = 2'd3
    } mb_code_e;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_EVAL  = 2'd1,
        S_WRITE = 2'd2,
        S_PEND  = 2'd3
    } eng_state_e;
endpackage

// File: rtl/can_rxm_masks.sv
module can_rxm_masks #(
    parameter int NUM_MB = 16,
    parameter int ID_W   = 11,
    parameter int LEG_A  = 14,
    parameter int LEG_B  = 15,
    localparam int IDX_W = $clog2(NUM_MB)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           compat_en,
    input  logic                           freeze,
    input  logic                           msk_we,
    input  logic                           msk_leg,
    input  logic [IDX_W-1:0]               msk_sel,
    input  logic [ID_W-1:0]                msk_val,
    output logic [NUM_MB-1:0][ID_W-1:0]    eff_mask
);
    logic [NUM_MB-1:0][ID_W-1:0] ind_q;
    logic [ID_W-1:0] glb_q, leg_a_q, leg_b_q;

    // per-mailbox masks live in RAM: no reset value
    always_ff @(posedge clk) begin
        if (msk_we && !msk_leg && compat_en && freeze)
            ind_q[msk_sel] <= msk_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            glb_q   <= '1;
            leg_a_q <= '1;
            leg_b_q <= '1;
        end else if (msk_we && msk_leg && freeze) begin
            if (msk_sel == IDX_W'(0)) glb_q   <= msk_val;
            if (msk_sel == IDX_W'(1)) leg_a_q <= msk_val;
            if (msk_sel == IDX_W'(2)) leg_b_q <= msk_val;
        end
    end

    for (genvar i = 0; i < NUM_MB; i++) begin : g_eff
        if (i == LEG_A) begin : g_a
            assign eff_mask[i] = compat_en ? ind_q[i] : leg_a_q;
        end else if (i == LEG_B) begin : g_b
            assign eff_mask[i] = compat_en ? ind_q[i] : leg_b_q;
        end else begin : g_g
            assign eff_mask[i] = compat_en ? ind_q[i] : glb_q;
        end
    end

    assert_ind_guard_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (msk_we && !msk_leg && !(compat_en && freeze)) |=> $stable(ind_q));
    assert_leg_guard_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (msk_we && msk_leg && !freeze) |=> $stable({glb_q, leg_a_q, leg_b_q}));
endmodule

// File: rtl/can_rxm_slots.sv
module can_rxm_slots
    import can_rxm_pkg::*;
#(
    parameter int NUM_MB = 16,
    parameter int ID_W   = 11,
    parameter int TS_W   = 16,
    localparam int IDX_W = $clog2(NUM_MB)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           cfg_we,
    input  logic [IDX_W-1:0]               cfg_idx,
    input  logic [ID_W-1:0]                cfg_id,
    input  logic                           cfg_on,
    input  logic                           lk_we,
    input  logic [IDX_W-1:0]               lk_idx,
    input  logic                           lk_set,
    input  logic                           st_en,
    input  logic [IDX_W-1:0]               st_idx,
    input  logic                           st_ovr,
    input  logic [ID_W-1:0]                st_id,
    input  logic [TS_W-1:0]                st_ts,
    output mb_code_e [NUM_MB-1:0]          code_o,
    output logic [NUM_MB-1:0][ID_W-1:0]    id_o,
    output logic [NUM_MB-1:0][ID_W-1:0]    fid_o,
    output logic [NUM_MB-1:0][TS_W-1:0]    ts_o,
    output logic [NUM_MB-1:0]              lock_o,
    output logic [NUM_MB-1:0]              free_o
);
    mb_code_e [NUM_MB-1:0]       code_q;
    logic [NUM_MB-1:0]           lock_q, svc_q;
    logic [NUM_MB-1:0][ID_W-1:0] id_q, fid_q;
    logic [NUM_MB-1:0][TS_W-1:0] ts_q;

    for (genvar i = 0; i < NUM_MB; i++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                code_q[i] <= CODE_INACTIVE;
                lock_q[i] <= 1'b0;
                svc_q[i]  <= 1'b0;
                id_q[i]   <= '0;
                fid_q[i]  <= '0;
                ts_q[i]   <= '0;
            end else begin
                if (cfg_we && cfg_idx == IDX_W'(i)) begin
                    code_q[i] <= cfg_on ? CODE_EMPTY : CODE_INACTIVE;
                    id_q[i]   <= cfg_id;
                    svc_q[i]  <= 1'b0;
                end
                if (lk_we && lk_idx == IDX_W'(i)) begin
                    lock_q[i] <= lk_set;
                    if (!lk_set && lock_q[i]) svc_q[i] <= 1'b1;
                end
                if (st_en && st_idx == IDX_W'(i)) begin
                    code_q[i] <= st_ovr ? CODE_OVERRUN : CODE_FULL;
                    fid_q[i]  <= st_id;
                    ts_q[i]   <= st_ts;
                    svc_q[i]  <= 1'b0;
                end
            end
        end
        assign free_o[i] = !lock_q[i] && ((code_q[i] == CODE_EMPTY) ||
                           ((code_q[i] == CODE_FULL || code_q[i] == CODE_OVERRUN) && svc_q[i]));
    end

    assign code_o = code_q;
    assign id_o   = id_q;
    assign fid_o  = fid_q;
    assign ts_o   = ts_q;
    assign lock_o = lock_q;

    assert_store_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
        st_en |=> (code_q[$past(st_idx)] == ($past(st_ovr) ? CODE_OVERRUN : CODE_FULL)));
    assert_store_svc_R4: assert property (@(posedge clk) disable iff (!rst_n)
        st_en |=> !svc_q[$past(st_idx)]);
endmodule

// File: rtl/can_rxm_pick.sv
module can_rxm_pick #(
    parameter int NUM_MB = 16,
    parameter int ID_W   = 11,
    localparam int IDX_W = $clog2(NUM_MB)
) (
    input  logic [ID_W-1:0]                smb_id,
    input  logic                           compat_en,
    input  logic [NUM_MB-1:0]              active,
    input  logic [NUM_MB-1:0]              free,
    input  logic [NUM_MB-1:0]              locked,
    input  logic [NUM_MB-1:0][ID_W-1:0]    mb_id,
    input  logic [NUM_MB-1:0][ID_W-1:0]    mb_mask,
    output logic                           hit_o,
    output logic [IDX_W-1:0]               tgt_o,
    output logic                           ovr_o,
    output logic                           hold_o
);
    logic [NUM_MB-1:0] match;
    logic              any_m, ff_hit;
    logic [IDX_W-1:0]  first_m, last_m, first_free;

    for (genvar i = 0; i < NUM_MB; i++) begin : g_match
        assign match[i] = active[i] && (((mb_id[i] ^ smb_id) & mb_mask[i]) == '0);
    end

    always_comb begin
        any_m = 1'b0; ff_hit = 1'b0;
        first_m = '0; last_m = '0; first_free = '0;
        for (int i = NUM_MB - 1; i >= 0; i--) begin
            if (match[i]) first_m = IDX_W'(i);
            if (match[i] && free[i]) begin
                ff_hit     = 1'b1;
                first_free = IDX_W'(i);
            end
        end
        for (int i = 0; i < NUM_MB; i++) begin
            if (match[i]) begin
                any_m  = 1'b1;
                last_m = IDX_W'(i);
            end
        end
    end

    always_comb begin
        hit_o = any_m;
        if (compat_en) begin
            tgt_o  = ff_hit ? first_free : last_m;
            ovr_o  = !ff_hit;
            hold_o = !ff_hit && locked[last_m];
        end else begin
            tgt_o  = first_m;
            ovr_o  = !free[first_m];
            hold_o = locked[first_m];
        end
    end
endmodule

// File: rtl/can_rx_mbox_match.sv
module can_rx_mbox_match
    import can_rxm_pkg::*;
#(
    parameter int NUM_MB = 16,
    parameter int ID_W   = 11,
    parameter int TS_W   = 16,
    localparam int IDX_W = $clog2(NUM_MB)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frm_valid,
    input  logic [ID_W-1:0]   frm_id,
    input  logic              compat_en,
    input  logic              freeze,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [ID_W-1:0]   cfg_id,
    input  logic              cfg_on,
    input  logic              lk_we,
    input  logic [IDX_W-1:0]  lk_idx,
    input  logic              lk_set,
    input  logic              msk_we,
    input  logic              msk_leg,
    input  logic [IDX_W-1:0]  msk_sel,
    input  logic [ID_W-1:0]   msk_val,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [1:0]        rd_code,
    output logic [TS_W-1:0]   rd_ts,
    output logic [ID_W-1:0]   rd_fid,
    output logic [NUM_MB-1:0] irq_o
);
    eng_state_e state_q, state_d;
    logic [ID_W-1:0]  smb_q;
    logic [IDX_W-1:0] tgt_q;
    logic             ovr_q;
    logic [TS_W-1:0]  ts_q;
    logic [NUM_MB-1:0] irq_q;

    mb_code_e [NUM_MB-1:0]       code_arr;
    logic [NUM_MB-1:0][ID_W-1:0] id_arr, fid_arr, mask_arr;
    logic [NUM_MB-1:0][TS_W-1:0] ts_arr;
    logic [NUM_MB-1:0]           lock_arr, free_arr, act_arr;
    logic                        hit, ovr, hold, st_en;
    logic [IDX_W-1:0]            tgt;

    for (genvar i = 0; i < NUM_MB; i++) begin : g_act
        assign act_arr[i] = (code_arr[i] != CODE_INACTIVE);
    end

    can_rxm_masks #(.NUM_MB(NUM_MB), .ID_W(ID_W)) u_masks (
        .clk(clk), .rst_n(rst_n), .compat_en(compat_en), .freeze(freeze),
        .msk_we(msk_we), .msk_leg(msk_leg), .msk_sel(msk_sel), .msk_val(msk_val),
        .eff_mask(mask_arr)
    );

    can_rxm_slots #(.NUM_MB(NUM_MB), .ID_W(ID_W), .TS_W(TS_W)) u_slots (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_id(cfg_id), .cfg_on(cfg_on),
        .lk_we(lk_we), .lk_idx(lk_idx), .lk_set(lk_set),
        .st_en(st_en), .st_idx(tgt_q), .st_ovr(ovr_q), .st_id(smb_q), .st_ts(ts_q),
        .code_o(code_arr), .id_o(id_arr), .fid_o(fid_arr), .ts_o(ts_arr),
        .lock_o(lock_arr), .free_o(free_arr)
    );

    can_rxm_pick #(.NUM_MB(NUM_MB), .ID_W(ID_W)) u_pick (
        .smb_id(smb_q), .compat_en(compat_en), .active(act_arr), .free(free_arr),
        .locked(lock_arr), .mb_id(id_arr), .mb_mask(mask_arr),
        .hit_o(hit), .tgt_o(tgt), .ovr_o(ovr), .hold_o(hold)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (frm_valid) state_d = S_EVAL;
            S_EVAL:  state_d = !hit ? S_IDLE : (hold ? S_PEND : S_WRITE);
            S_WRITE: state_d = S_IDLE;
            S_PEND:  if (!lock_arr[tgt_q]) state_d = S_EVAL;
        endcase
    end

    assign st_en = (state_q == S_WRITE);

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smb_q <= '0;
            tgt_q <= '0;
            ovr_q <= 1'b0;
            ts_q  <= '0;
            irq_q <= '0;
        end else begin
            ts_q  <= ts_q + TS_W'(1);
            irq_q <= '0;
            unique case (state_q)
                S_IDLE:  if (frm_valid) smb_q <= frm_id;
                S_EVAL:  begin tgt_q <= tgt; ovr_q <= ovr; end
                S_WRITE: irq_q[tgt_q] <= 1'b1;
                S_PEND:  ;
            endcase
        end
    end

    assign irq_o   = irq_q;
    assign rd_code = code_arr[rd_idx];
    assign rd_ts   = ts_arr[rd_idx];
    assign rd_fid  = fid_arr[rd_idx];

    assert_irq_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq_o));
    assert_write_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WRITE) |=> ($countones(irq_o) == 1));
    assert_pend_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_PEND) |-> (irq_o == '0));
    assert_ts_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (ts_q == $past(ts_q) + TS_W'(1)));
endmodule

// File: tb/can_rx_mbox_match_tb.sv
module can_rx_mbox_match_tb_top;
    localparam int NUM_MB = 16;
    localparam int ID_W   = 11;
    localparam int TS_W   = 16;
    localparam int IDX_W  = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic frm_valid = 0, compat_en = 1, freeze = 1;
    logic [ID_W-1:0] frm_id = '0, cfg_id = '0, msk_val = '0;
    logic cfg_we = 0, cfg_on = 0, lk_we = 0, lk_set = 0, msk_we = 0, msk_leg = 0;
    logic [IDX_W-1:0] cfg_idx = '0, lk_idx = '0, msk_sel = '0, rd_idx = '0;
    logic [1:0] rd_code;
    logic [TS_W-1:0] rd_ts;
    logic [ID_W-1:0] rd_fid;
    logic [NUM_MB-1:0] irq_o;

    int n_tot = 0, n_fail = 0;

    // bench model of the mailboxes
    int m_code [NUM_MB];
    bit m_lock [NUM_MB];
    bit m_svc  [NUM_MB];
    int m_id   [NUM_MB];
    int m_msk  [NUM_MB];
    int m_fid  [NUM_MB];
    int ml_g = 'h7FF, ml_a = 'h7FF, ml_b = 'h7FF;

    always #5 clk = ~clk;

    can_rx_mbox_match #(.NUM_MB(NUM_MB), .ID_W(ID_W), .TS_W(TS_W)) dut_i (.*);

    initial begin
        for (int c = 0; c < 150000; c++) @(posedge clk);
        n_tot++; n_fail++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("%0d/%0d checks passed", n_tot - n_fail, n_tot);
        $finish;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_tot++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit is_free(input int i);
        return !m_lock[i] && (m_code[i] == 1 || ((m_code[i] >= 2) && m_svc[i]));
    endfunction

    function automatic int eff_mask(input int i, input bit cm);
        if (cm) return m_msk[i];
        if (i == 14) return ml_a;
        if (i == 15) return ml_b;
        return ml_g;
    endfunction

    // returns target index or -1; ovr/hold describe the decision
    function automatic int predict(input int id, input bit cm, output bit ovr, output bit hold);
        int first = -1, last = -1, ffree = -1;
        ovr = 0; hold = 0;
        for (int i = 0; i < NUM_MB; i++) begin
            if (m_code[i] != 0 && (((m_id[i] ^ id) & eff_mask(i, cm)) == 0)) begin
                if (first < 0) first = i;
                last = i;
                if (ffree < 0 && is_free(i)) ffree = i;
            end
        end
        if (first < 0) return -1;
        if (cm) begin
            if (ffree >= 0) return ffree;
            ovr = 1; hold = m_lock[last]; return last;
        end
        ovr = !is_free(first); hold = m_lock[first];
        return first;
    endfunction

    task automatic cfg(input int idx, input int id, input bit on);
        @(negedge clk);
        cfg_we = 1; cfg_idx = IDX_W'(idx); cfg_id = ID_W'(id); cfg_on = on;
        @(negedge clk);
        cfg_we = 0;
        m_code[idx] = on ? 1 : 0; m_id[idx] = id; m_svc[idx] = 0;
    endtask

    task automatic lock_op(input int idx, input bit set);
        @(negedge clk);
        lk_we = 1; lk_idx = IDX_W'(idx); lk_set = set;
        @(negedge clk);
        lk_we = 0;
        if (!set && m_lock[idx]) m_svc[idx] = 1;
        m_lock[idx] = set;
    endtask

    // model update follows R9 acceptance rules
    task automatic mask_wr(input bit leg, input int sel, input int val);
        @(negedge clk);
        msk_we = 1; msk_leg = leg; msk_sel = IDX_W'(sel); msk_val = ID_W'(val);
        @(negedge clk);
        msk_we = 0;
        if (!leg && compat_en && freeze) m_msk[sel] = val;
        if (leg && freeze) begin
            if (sel == 0) ml_g = val;
            if (sel == 1) ml_a = val;
            if (sel == 2) ml_b = val;
        end
    endtask

    // strobe at edge k; returns after edge k+2, irq sampled there
    task automatic send(input int id);
        @(negedge clk);
        frm_valid = 1; frm_id = ID_W'(id);
        @(negedge clk);
        frm_valid = 0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic check_store(input string req, input int exp_idx, input bit ovr, input int id);
        if (exp_idx < 0) begin
            chk(req, int'(irq_o), 0);
        end else begin
            chk(req, int'(irq_o), 1 << exp_idx);
            m_code[exp_idx] = ovr ? 3 : 2; m_svc[exp_idx] = 0; m_fid[exp_idx] = id;
            rd_idx = IDX_W'(exp_idx); #1;
            chk(req, int'(rd_code), m_code[exp_idx]);
            chk(req, int'(rd_fid), id);
        end
    endtask

    // returns 1 when the frame was held
    task automatic frame(input string req, input int id, output bit held, output int slot);
        bit ovr, hold;
        int t;
        t = predict(id, compat_en, ovr, hold);
        send(id);
        held = (t >= 0) && hold;
        slot = t;
        if (held) chk(req, int'(irq_o), 0);
        else check_store(req, t, ovr, id);
    endtask

    // unlock the blocking slot; held frame lands three edges after the unlock edge
    task automatic release_held(input string req, input int slot, input int id);
        bit ovr, hold;
        int t;
        lock_op(slot, 0);
        t = predict(id, compat_en, ovr, hold);
        @(negedge clk); @(negedge clk);
        chk(req, int'(irq_o), 0);
        @(negedge clk);
        check_store(req, t, ovr, id);
    endtask

    initial begin
        bit held;
        int slot;
        int ts_a;
        void'($urandom(32'd20231));
        for (int i = 0; i < NUM_MB; i++) begin
            m_code[i] = 0; m_lock[i] = 0; m_svc[i] = 0; m_id[i] = 0; m_msk[i] = 0; m_fid[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1: reset state
        begin
            int nz = 0;
            for (int i = 0; i < NUM_MB; i++) begin
                rd_idx = IDX_W'(i); #1;
                if (rd_code != 2'd0) nz++;
            end
            chk("R1 codes inactive", nz, 0);
            chk("R1 irq idle", int'(irq_o), 0);
        end

        // program per-slot masks (queue mode, freeze)
        for (int i = 0; i < NUM_MB; i++) mask_wr(0, i, 'h7FF);
        mask_wr(0, 8, 'h700);
        cfg(2, 'h123, 1); cfg(5, 'h123, 1); cfg(8, 'h200, 1);
        rd_idx = 4'd2; #1;
        chk("R1 cfg makes EMPTY", int'(rd_code), 1);

        // R11: no match
        frame("R11 no match", 'h555, held, slot);
        rd_idx = 4'd2; #1;
        chk("R11 slot untouched", int'(rd_code), 1);

        // R3, R10, R5: queue across same ID
        frame("R3 first free", 'h123, held, slot);
        chk("R3 lands slot2", slot, 2);
        rd_idx = 4'd2; #1; ts_a = int'(rd_ts);
        frame("R3 skip busy", 'h123, held, slot);
        chk("R3 lands slot5", slot, 5);
        rd_idx = 4'd5; #1;
        chk("R10 ts spacing", int'(rd_ts) - ts_a, 4);
        frame("R5 overrun last", 'h123, held, slot);
        rd_idx = 4'd5; #1;
        chk("R5 code overrun", int'(rd_code), 3);

        // R2: masked compare
        frame("R2 dont care bits", 'h2AB, held, slot);
        chk("R2 lands slot8", slot, 8);
        frame("R2 cared bit differs", 'h3AB, held, slot);

        // R4: serviced slot becomes free again
        lock_op(2, 1); lock_op(2, 0);
        frame("R4 serviced reused", 'h123, held, slot);
        chk("R4 lands slot2", slot, 2);

        // R6: last match locked -> hold, later frames ignored
        lock_op(5, 1);
        frame("R6 hold", 'h123, held, slot);
        chk("R6 held flag", int'(held), 1);
        send('h255);
        chk("R6 strobe ignored while held", int'(irq_o), 0);
        rd_idx = 4'd8; #1;
        chk("R6 slot8 untouched", int'(rd_fid), 'h2AB);
        release_held("R6 store after unlock", 5, 'h123);

        // R9: mask writes outside freeze or legacy are ignored
        freeze = 0;
        mask_wr(0, 8, 'h7FF);
        frame("R9 write ignored no freeze", 'h2CC, held, slot);
        chk("R9 slot8 still wide", slot, 8);
        freeze = 1; compat_en = 0;
        mask_wr(0, 8, 'h7FF);
        compat_en = 1;
        frame("R9 write ignored legacy", 'h2DD, held, slot);
        chk("R9 slot8 still wide 2", slot, 8);

        // R7, R8: legacy mode
        compat_en = 0;
        mask_wr(1, 0, 'h7FF); mask_wr(1, 1, 'h7F0); mask_wr(1, 2, 'h7FF);
        freeze = 0;
        mask_wr(1, 0, 'h000);
        freeze = 1;
        cfg(2, 'h123, 1); cfg(5, 'h123, 1); cfg(8, 'h200, 0); cfg(14, 'h100, 1);
        frame("R8 dedicated mask slot14", 'h10F, held, slot);
        chk("R8 lands slot14", slot, 14);
        frame("R7 first match", 'h123, held, slot);
        chk("R7 lands slot2", slot, 2);
        frame("R7 overwrite first", 'h123, held, slot);
        chk("R7 stays slot2", slot, 2);
        rd_idx = 4'd5; #1;
        chk("R7 slot5 still empty", int'(rd_code), 1);
        lock_op(2, 1);
        frame("R7 locked hold", 'h123, held, slot);
        chk("R7 held", int'(held), 1);
        release_held("R7 release", 2, 'h123);
        cfg(3, 'h10F, 1);
        frame("R8 global mask first", 'h10F, held, slot);
        chk("R8 lands slot3", slot, 3);

        // random phase, queue mode
        compat_en = 1; freeze = 1;
        for (int i = 0; i < NUM_MB; i++) begin
            if (m_lock[i]) lock_op(i, 0);
            mask_wr(0, i, ($urandom_range(0, 1) != 0) ? 'h7FF : 'h7FE);
            cfg(i, 'h0A0 + $urandom_range(0, 1), $urandom_range(0, 2) != 0);
        end
        for (int n = 0; n < 200; n++) begin
            int op = $urandom_range(0, 9);
            if (op < 2) lock_op($urandom_range(0, NUM_MB - 1), 1);
            else if (op < 4) lock_op($urandom_range(0, NUM_MB - 1), 0);
            else begin
                int id = 'h0A0 + $urandom_range(0, 3);
                frame("R3 R5 random frame", id, held, slot);
                if (held) release_held("R6 random release", slot, id);
            end
        end

        $display("%0d/%0d checks passed", n_tot - n_fail, n_tot);
        $finish;
    end
endmodule